// File: doc/BRIEF.md
# Full-Bridge Gate Sequencer

This block turns per-leg switch commands into four gate-enable signals for a two-leg H-bridge (legs indexed 0 and 1). Each leg has a high-side and a low-side command. One disable input overrides them all. The commands and the disable pass through a two-flop synchronizer. The block then settles conflicts inside each leg, with the low side winning. It also keeps the high-side enables off for a short window after the disable is released.

Each gate enable goes through its own turn-on timer. An enable goes high only after its request has stayed present for a programmed number of cycles. The high sides share one setting and the low sides share another. An enable drops on the first cycle its request goes away. When the disable is released, both low-side switches are requested for a programmed number of cycles so that the bootstrap capacitors can recharge. The high sides stay blocked until a second programmed interval has also run out. The four timing settings are quasi-static and are changed only while the bridge is disabled.

Top module: `fb_gate_ctrl`

## Requirements
- R1: During reset and after it, every gate enable is low. The synchronizer flops reset to logic high, so the block comes up disabled and stays quiet until a low disable has crossed the synchronizer.
- R2: When the synchronized disable is high, all four gate enables are low. After the disable pin rises, the enables are low from the third rising edge on, counting the edge that first samples the pin as edge 1.
- R3: In a leg whose low-side command is high, the low-side enable is requested and the high-side enable is off, even when that leg's high-side command is also high.
- R4: In a leg whose high-side command is high and low-side command is low, the high-side enable is requested and the low-side enable is off. The other leg is unaffected.
- R5: In a leg whose two commands are both low, both enables are off.
- R6: A high-side enable rises at edge 3 + hi_dly after its request first arrives at the pin. hi_dly is one 8-bit cycle count shared by both legs, and 0 gives turn-on at edge 3.
- R7: A low-side enable rises at edge 3 + lo_dly under the same counting. lo_dly is shared by both legs.
- R8: An enable whose request goes away falls at edge 3, with no programmed delay.
- R9: A request that goes away before its delay has run out produces no pulse. A new request restarts the delay from zero.
- R10: When the synchronized disable falls, both low-side enables are requested for refresh_len cycles, starting in the first cycle the release is seen. These requests still obey R7, so the visible pulse lasts refresh_len - lo_dly cycles when that is positive. A refresh_len of 0 gives no refresh.
- R11: From that same cycle, high-side requests are ignored for max(refresh_len, upper_hold) cycles. With both set to 0, a high-side command present at the release turns on at edge 3 + hi_dly.
- R12: A leg whose high-side command is held high is controlled by its low-side command alone: low-side command high gives low on, and low gives high on.
- R13: The high-side and low-side enables of one leg are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dis_in | input | 1 | Disable; high forces all enables off |
| hi_cmd | input | LEGS | High-side command per leg, asynchronous |
| lo_cmd | input | LEGS | Low-side command per leg, asynchronous |
| hi_dly | input | CW | High-side turn-on delay in cycles |
| lo_dly | input | CW | Low-side turn-on delay in cycles |
| refresh_len | input | CW | Low-side refresh length after a disable release, in cycles |
| upper_hold | input | CW | High-side block after a disable release, in cycles |
| hi_gate | output | LEGS | High-side gate enable per leg |
| lo_gate | output | LEGS | Low-side gate enable per leg |

## Verification
The bench times the turn-on edge exactly after a change in commands. A design that reached the delay one cycle early, or counted it on turn-off, moves that edge and is reported. A short request followed by a re-request catches a counter that is not cleared: that design turns on three cycles early, and one that ignores cancellation emits a stray pulse. Disable releases are run with both hold settings non-zero and with both at zero. This exposes a high side that slips through before the refresh has finished, a refresh of the wrong width, and a block that stalls when its settings are zero. Random command and disable traffic with shifting timing settings is compared every cycle against a reference model, and the bench checks that no leg ever shows both enables high.

// File: rtl/fb_pkg.sv
// Package fb_pkg
// Types shared by the full-bridge gate sequencer.
// Assumes: one leg is a high-side and a low-side switch in series.
package fb_pkg;

    // Resolved per-leg request, before the turn-on timers
    typedef struct packed {
        logic hi;
        logic lo;
    } leg_req_t;

endpackage

// File: rtl/fb_input_sync.sv
// Module fb_input_sync
// Two-flop synchronizer for a vector of independent single-bit inputs.
// Assumes: the bits are unrelated levels, so each bit may resolve a cycle
// apart from its neighbours. On reset both stages load RST_LVL.
module fb_input_sync #(
    parameter int   W       = 5,
    parameter logic RST_LVL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta;

    // Two-stage capture of the asynchronous inputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= {W{RST_LVL}};
            q    <= {W{RST_LVL}};
        end else begin
            meta <= d;
            q    <= meta;
        end
    end

endmodule

// File: rtl/fb_refresh_seq.sv
// Module fb_refresh_seq
// Watches the synchronized disable. On its falling edge the module opens a
// low-side refresh window of refresh_len cycles and a high-side block
// window that lasts max(refresh_len, upper_hold) cycles. Both windows
// include the cycle in which the release is first seen.
// Assumes: refresh_len and upper_hold are static while the bridge runs.
// A new disable cancels both windows at once.
module fb_refresh_seq #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dis_s,
    input  logic [CW-1:0] refresh_len,
    input  logic [CW-1:0] upper_hold,
    output logic          refresh_on,
    output logic          upper_block
);

    logic          dis_d;
    logic [CW-1:0] rf_left;
    logic [CW-1:0] up_left;
    logic          release_now;

    // Detect the cycle in which the disable is first seen low
    always_comb begin
        release_now = dis_d & ~dis_s;
    end

    // Window outputs: live in the release cycle and while cycles remain
    always_comb begin
        refresh_on  = ~dis_s & ((release_now & (refresh_len != '0)) | (rf_left != '0));
        upper_block = ~dis_s & (refresh_on
                                | (release_now & (upper_hold != '0))
                                | (up_left != '0));
    end

    // Remaining-cycle counters for both windows
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dis_d   <= 1'b1;
            rf_left <= '0;
            up_left <= '0;
        end else begin
            dis_d <= dis_s;
            if (dis_s) begin
                rf_left <= '0;
                up_left <= '0;
            end else if (release_now) begin
                rf_left <= (refresh_len == '0) ? '0 : refresh_len - 1'b1;
                up_left <= (upper_hold  == '0) ? '0 : upper_hold  - 1'b1;
            end else begin
                if (rf_left != '0) rf_left <= rf_left - 1'b1;
                if (up_left != '0) up_left <= up_left - 1'b1;
            end
        end
    end

endmodule

// File: rtl/fb_leg_arbiter.sv
// Module fb_leg_arbiter
// Combinational resolver for one leg. Disable clears both requests. The
// low-side command or a refresh window requests the low side. The high
// side is requested only when the low side is not commanded and no
// post-release block is active.
// Assumes: inputs are already synchronized. refresh_on implies upper_block.
module fb_leg_arbiter
    import fb_pkg::*;
(
    input  logic     dis_s,
    input  logic     hi_cmd,
    input  logic     lo_cmd,
    input  logic     refresh_on,
    input  logic     upper_block,
    output leg_req_t req
);

    // Fixed priority: disable, then low side, then high side
    always_comb begin
        req.lo = ~dis_s & (lo_cmd | refresh_on);
        req.hi = ~dis_s & hi_cmd & ~lo_cmd & ~refresh_on & ~upper_block;
    end

endmodule

// File: rtl/fb_turnon_delay.sv
// Module fb_turnon_delay
// Turn-on delay for one gate enable. The age counter counts the cycles for
// which the request has been present. The gate rises once the age reaches
// dly and drops in the first cycle the request is absent. Dropping the
// request clears the age, so each new request waits the full delay.
// Assumes: dly is static while the request is present.
module fb_turnon_delay #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic [CW-1:0] dly,
    output logic          gate
);

    logic [CW-1:0] age;

    // Age the request and open the gate once the delay has elapsed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age  <= '0;
            gate <= 1'b0;
        end else begin
            gate <= req && (age >= dly);
            if (!req) begin
                age <= '0;
            end else if (age != '1) begin
                age <= age + 1'b1;
            end
        end
    end

endmodule

// File: rtl/fb_gate_ctrl.sv
// Module fb_gate_ctrl
// Gate sequencer for a bridge with LEGS half-bridge legs. It synchronizes
// the commands and the disable, settles the requests per leg, runs the
// refresh and block windows after a disable release, and times each
// enable's turn-on separately.
// Assumes: the timing inputs change only while the bridge is disabled.
// The synchronizer resets high, so the block starts out disabled.
module fb_gate_ctrl
    import fb_pkg::*;
#(
    parameter int LEGS = 2,
    parameter int CW   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dis_in,
    input  logic [LEGS-1:0] hi_cmd,
    input  logic [LEGS-1:0] lo_cmd,
    input  logic [CW-1:0]   hi_dly,
    input  logic [CW-1:0]   lo_dly,
    input  logic [CW-1:0]   refresh_len,
    input  logic [CW-1:0]   upper_hold,
    output logic [LEGS-1:0] hi_gate,
    output logic [LEGS-1:0] lo_gate
);

    localparam int SW = 2 * LEGS + 1;

    logic [SW-1:0]   sync_q;
    logic            dis_s;
    logic [LEGS-1:0] hi_s;
    logic [LEGS-1:0] lo_s;
    logic            refresh_on;
    logic            upper_block;
    logic [LEGS-1:0] hi_req;
    logic [LEGS-1:0] lo_req;
    leg_req_t        leg_req [LEGS];

    fb_input_sync #(
        .W      (SW),
        .RST_LVL(1'b1)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({dis_in, hi_cmd, lo_cmd}),
        .q    (sync_q)
    );

    // Split the synchronized vector into its fields
    always_comb begin
        dis_s = sync_q[SW-1];
        hi_s  = sync_q[2*LEGS-1:LEGS];
        lo_s  = sync_q[LEGS-1:0];
    end

    fb_refresh_seq #(
        .CW(CW)
    ) u_refresh (
        .clk        (clk),
        .rst_n      (rst_n),
        .dis_s      (dis_s),
        .refresh_len(refresh_len),
        .upper_hold (upper_hold),
        .refresh_on (refresh_on),
        .upper_block(upper_block)
    );

    for (genvar g = 0; g < LEGS; g++) begin : g_leg
        fb_leg_arbiter u_arb (
            .dis_s      (dis_s),
            .hi_cmd     (hi_s[g]),
            .lo_cmd     (lo_s[g]),
            .refresh_on (refresh_on),
            .upper_block(upper_block),
            .req        (leg_req[g])
        );

        // Flatten the leg's request for the timers and the checker
        always_comb begin
            hi_req[g] = leg_req[g].hi;
            lo_req[g] = leg_req[g].lo;
        end

        fb_turnon_delay #(
            .CW(CW)
        ) u_hi_dly (
            .clk  (clk),
            .rst_n(rst_n),
            .req  (hi_req[g]),
            .dly  (hi_dly),
            .gate (hi_gate[g])
        );

        fb_turnon_delay #(
            .CW(CW)
        ) u_lo_dly (
            .clk  (clk),
            .rst_n(rst_n),
            .req  (lo_req[g]),
            .dly  (lo_dly),
            .gate (lo_gate[g])
        );
    end

endmodule

// File: rtl/fb_gate_ctrl_chk.sv
// Module fb_gate_ctrl_chk
// Property checker bound into fb_gate_ctrl. It relates the synchronized
// disable, the window outputs, the resolved requests and the gate enables.
// Assumes: it is attached through the bind statement at the end of this file.
module fb_gate_ctrl_chk #(
    parameter int LEGS = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            dis_s,
    input logic            refresh_on,
    input logic            upper_block,
    input logic [LEGS-1:0] hi_req,
    input logic [LEGS-1:0] lo_req,
    input logic [LEGS-1:0] hi_gate,
    input logic [LEGS-1:0] lo_gate
);

    // R13: no leg drives both of its switches at once
    a_r13_leg_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_gate & lo_gate) == '0);

    // R2: a synchronized disable clears every enable on the next edge
    a_r2_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        dis_s |=> (hi_gate == '0 && lo_gate == '0));

    // R11: the post-release block keeps the high sides off
    a_r11_upper_hold: assert property (@(posedge clk) disable iff (!rst_n)
        upper_block |=> hi_gate == '0);

    // R10: a refresh window requests every low side
    a_r10_refresh_low_req: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_on |-> lo_req == '1);

    for (genvar g = 0; g < LEGS; g++) begin : g_leg_chk
        // R3: a low-side request excludes the high-side request
        a_r3_low_wins: assert property (@(posedge clk) disable iff (!rst_n)
            lo_req[g] |-> !hi_req[g]);

        // R8: a missing high-side request closes that gate on the next edge
        a_r8_hi_prompt_off: assert property (@(posedge clk) disable iff (!rst_n)
            !hi_req[g] |=> !hi_gate[g]);

        // R8: a missing low-side request closes that gate on the next edge
        a_r8_lo_prompt_off: assert property (@(posedge clk) disable iff (!rst_n)
            !lo_req[g] |=> !lo_gate[g]);
    end

endmodule

bind fb_gate_ctrl fb_gate_ctrl_chk #(.LEGS(LEGS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dis_s      (dis_s),
    .refresh_on (refresh_on),
    .upper_block(upper_block),
    .hi_req     (hi_req),
    .lo_req     (lo_req),
    .hi_gate    (hi_gate),
    .lo_gate    (lo_gate)
);

// File: tb/fb_gate_ctrl_tb.sv
`timescale 1ns/1ps
// Bench for fb_gate_ctrl: directed corner cases plus seeded random traffic,
// compared every cycle against a cycle model written from the requirements.
module fb_gate_ctrl_tb;

    localparam int LEGS     = 2;
    localparam int CW       = 8;
    localparam int AGE_MAX  = (1 << CW) - 1;
    localparam int IDLE_REL = 100000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            dis_in = 1'b1;
    logic [LEGS-1:0] hi_cmd = '1;
    logic [LEGS-1:0] lo_cmd = '1;
    logic [CW-1:0]   hi_dly = '0;
    logic [CW-1:0]   lo_dly = '0;
    logic [CW-1:0]   refresh_len = '0;
    logic [CW-1:0]   upper_hold = '0;
    logic [LEGS-1:0] hi_gate;
    logic [LEGS-1:0] lo_gate;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    bit            m1_dis, m2_dis, m_dis_d;
    bit [LEGS-1:0] m1_hi, m1_lo, m2_hi, m2_lo;
    bit [LEGS-1:0] m_hi_out, m_lo_out;
    int            m_age_hi [LEGS];
    int            m_age_lo [LEGS];
    int            m_rel;
    string         m_tag_hi, m_tag_lo;

    always #2 clk = ~clk;

    fb_gate_ctrl #(.LEGS(LEGS), .CW(CW)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .dis_in     (dis_in),
        .hi_cmd     (hi_cmd),
        .lo_cmd     (lo_cmd),
        .hi_dly     (hi_dly),
        .lo_dly     (lo_dly),
        .refresh_len(refresh_len),
        .upper_hold (upper_hold),
        .hi_gate    (hi_gate),
        .lo_gate    (lo_gate)
    );

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int imin(int a, int b);
        return (a < b) ? a : b;
    endfunction

    function automatic logic probe(int idx);
        case (idx)
            0:       return hi_gate[0];
            1:       return hi_gate[1];
            2:       return lo_gate[0];
            default: return lo_gate[1];
        endcase
    endfunction

    task automatic model_reset();
        m1_dis = 1'b1; m2_dis = 1'b1; m_dis_d = 1'b1;
        m1_hi = '1; m1_lo = '1; m2_hi = '1; m2_lo = '1;
        m_hi_out = '0; m_lo_out = '0;
        for (int i = 0; i < LEGS; i++) begin
            m_age_hi[i] = 0;
            m_age_lo[i] = 0;
        end
        m_rel = IDLE_REL;
        m_tag_hi = "R1";
        m_tag_lo = "R1";
    endtask

    // one rising edge of the model, using the inputs driven now
    task automatic model_step();
        int rel_now;
        bit refr, blk;
        rel_now = (m_dis_d && !m2_dis) ? 0 : m_rel;
        refr = !m2_dis && (rel_now < int'(refresh_len));
        blk  = !m2_dis && (rel_now < imax(int'(refresh_len), int'(upper_hold)));
        m_tag_hi = m2_dis ? "R2" : (blk ? "R11" : "R6");
        m_tag_lo = m2_dis ? "R2" : (refr ? "R10" : "R7");
        for (int i = 0; i < LEGS; i++) begin
            bit want_lo, want_hi;
            want_lo = !m2_dis && (m2_lo[i] || refr);
            want_hi = !m2_dis && m2_hi[i] && !m2_lo[i] && !blk;
            m_lo_out[i] = want_lo && (m_age_lo[i] >= int'(lo_dly));
            m_hi_out[i] = want_hi && (m_age_hi[i] >= int'(hi_dly));
            m_age_lo[i] = want_lo ? imin(m_age_lo[i] + 1, AGE_MAX) : 0;
            m_age_hi[i] = want_hi ? imin(m_age_hi[i] + 1, AGE_MAX) : 0;
        end
        m_rel   = m2_dis ? IDLE_REL : imin(rel_now + 1, IDLE_REL);
        m_dis_d = m2_dis;
        m2_dis  = m1_dis; m2_hi = m1_hi; m2_lo = m1_lo;
        m1_dis  = dis_in; m1_hi = hi_cmd; m1_lo = lo_cmd;
    endtask

    task automatic check(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_int(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // advance one clock and compare every enable with the model
    task automatic cycle(string tag);
        model_step();
        @(negedge clk);
        for (int i = 0; i < LEGS; i++) begin
            check((tag == "") ? m_tag_hi : tag, $sformatf("hi_gate[%0d]", i), hi_gate[i], m_hi_out[i]);
            check((tag == "") ? m_tag_lo : tag, $sformatf("lo_gate[%0d]", i), lo_gate[i], m_lo_out[i]);
        end
        check("R13", "both enables of a leg high", |(hi_gate & lo_gate), 1'b0);
    endtask

    task automatic wait_level(int idx, logic lvl, string tag, output int n);
        n = 0;
        for (int k = 1; k <= 300; k++) begin
            cycle(tag);
            if (probe(idx) === lvl) begin
                n = k;
                break;
            end
        end
    endtask

    initial begin
        int n, first_hi, lo_cnt;
        void'($urandom(32'd8191));
        model_reset();
        repeat (4) @(negedge clk);
        check("R1", "hi_gate during reset", |hi_gate, 1'b0);
        check("R1", "lo_gate during reset", |lo_gate, 1'b0);
        rst_n = 1'b1;
        // R1: pins left high keep the bridge disabled
        repeat (6) cycle("R1");
        check("R1", "enables after reset with pins high", |(hi_gate | lo_gate), 1'b0);

        // R10 R11: release with refresh and block windows
        hi_dly = 8'd3; lo_dly = 8'd2; refresh_len = 8'd4; upper_hold = 8'd6;
        dis_in = 1'b0; hi_cmd = 2'b11; lo_cmd = 2'b00;
        first_hi = 0; lo_cnt = 0;
        for (int k = 1; k <= 14; k++) begin
            cycle("");
            if (first_hi == 0 && hi_gate[0]) first_hi = k;
            if (lo_gate[0]) lo_cnt++;
        end
        check_int("R11", "first high-side turn-on cycle after release", first_hi, 12);
        check_int("R10", "visible refresh width on lo_gate[0]", lo_cnt, 2);

        // R3 R8 R7: low command overrides an active high side
        lo_cmd = 2'b01;
        wait_level(0, 1'b0, "R3", n);
        check_int("R8", "cycles to high-side turn-off", n, 3);
        wait_level(2, 1'b1, "R3", n);
        check_int("R7", "further cycles to low-side turn-on", n, 2);
        repeat (5) cycle("R3");
        check("R3", "hi_gate[0] with both commands high", hi_gate[0], 1'b0);
        check("R3", "lo_gate[0] with both commands high", lo_gate[0], 1'b1);
        check("R4", "other leg keeps its high side", hi_gate[1], 1'b1);

        // R8 R6 R4: low command released, high side returns after its delay
        lo_cmd = 2'b00;
        wait_level(2, 1'b0, "R8", n);
        check_int("R8", "cycles to low-side turn-off", n, 3);
        wait_level(0, 1'b1, "R6", n);
        check_int("R6", "further cycles to high-side turn-on", n, 3);
        check("R4", "lo_gate[0] with only high command", lo_gate[0], 1'b0);

        // R5: both commands low
        hi_cmd = 2'b00; lo_cmd = 2'b00;
        repeat (6) cycle("R5");
        check("R5", "enables with both commands low", |(hi_gate | lo_gate), 1'b0);

        // R9: short request is cancelled
        hi_cmd[0] = 1'b1;
        repeat (2) cycle("R9");
        hi_cmd[0] = 1'b0;
        lo_cnt = 0;
        for (int k = 0; k < 10; k++) begin
            cycle("R9");
            if (hi_gate[0]) lo_cnt++;
        end
        check_int("R9", "high-side pulses from a cancelled request", lo_cnt, 0);
        // R9: re-request restarts the delay
        hi_cmd[0] = 1'b1;
        repeat (3) cycle("R9");
        hi_cmd[0] = 1'b0;
        cycle("R9");
        hi_cmd[0] = 1'b1;
        wait_level(0, 1'b1, "R9", n);
        check_int("R9", "cycles to turn-on after re-request", n, 6);

        // R12: high command tied high, leg follows the low command
        hi_cmd = 2'b11; lo_cmd = 2'b00;
        repeat (10) cycle("R12");
        lo_cmd = 2'b10;
        repeat (10) cycle("R12");
        check("R12", "hi_gate[1] with low command high", hi_gate[1], 1'b0);
        check("R12", "lo_gate[1] with low command high", lo_gate[1], 1'b1);
        check("R12", "hi_gate[0] untouched", hi_gate[0], 1'b1);
        lo_cmd = 2'b00;
        repeat (10) cycle("R12");
        check("R12", "hi_gate[1] with low command low", hi_gate[1], 1'b1);
        check("R12", "lo_gate[1] with low command low", lo_gate[1], 1'b0);

        // R2: disable clears everything on the third edge
        dis_in = 1'b1;
        first_hi = 0;
        for (int k = 1; k <= 5; k++) begin
            cycle("R2");
            if (first_hi == 0 && (hi_gate | lo_gate) == '0) first_hi = k;
        end
        check_int("R2", "cycles until all enables low", first_hi, 3);
        hi_cmd = 2'b00; lo_cmd = 2'b11;
        repeat (5) cycle("R2");
        check("R2", "enables while disabled with low commands", |(hi_gate | lo_gate), 1'b0);

        // R11 R10: zero-length windows
        hi_dly = 8'd0; lo_dly = 8'd0; refresh_len = 8'd0; upper_hold = 8'd0;
        hi_cmd = 2'b11; lo_cmd = 2'b00; dis_in = 1'b0;
        first_hi = 0; lo_cnt = 0;
        for (int k = 1; k <= 8; k++) begin
            cycle("");
            if (first_hi == 0 && hi_gate[1]) first_hi = k;
            if (lo_gate[1]) lo_cnt++;
        end
        check_int("R11", "turn-on cycle with zero windows", first_hi, 3);
        check_int("R10", "refresh pulses with zero length", lo_cnt, 0);

        // random traffic against the model
        for (int c = 0; c < 3000; c++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 3) dis_in = ~dis_in;
            else if (r < 25) hi_cmd = LEGS'($urandom_range(0, (1 << LEGS) - 1));
            else if (r < 45) lo_cmd = LEGS'($urandom_range(0, (1 << LEGS) - 1));
            if (dis_in && m1_dis && m2_dis && m_dis_d && $urandom_range(0, 3) == 0) begin
                hi_dly      = CW'($urandom_range(0, 6));
                lo_dly      = CW'($urandom_range(0, 6));
                refresh_len = CW'($urandom_range(0, 9));
                upper_hold  = CW'($urandom_range(0, 12));
            end
            cycle("");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL R13 watchdog actual=running expected=finished at %0t", $time);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule